// File: doc/BRIEF.md
# Pulse-Injecting Dual Scan Chain Stage

This block serves one pipeline stage during test. It holds two serial chains of the same length that are clocked together. The data chain carries the static level for each logic input of the stage. The control chain carries one selector bit per input. After both chains are filled, an update copies them together into holding registers. These registers then drive a bank of per-bit multiplexers. When its selector bit is 1, a logic input follows a test pulse strobe that the whole stage shares. When its selector bit is 0, the input keeps its scanned level. The strobe only reaches the inputs while the block is in apply mode.

The data chain has one extra observation cell at its far end, after the last input bit. On the first apply cycle this cell records the monitored node of the preceding stage logic. On later apply cycles it keeps any high value that appears there. The cell is read out through the data serial output. Both serial outputs show the last cell of their chain, so stages can be cascaded.

A small controller turns the three request inputs into one operation per clock. It has four named states, and the state register remembers the previous operation:
- IDLE: nothing is requested.
- SHIFT: shift_en is high.
- UPDATE: update_en is high and shift_en is low.
- APPLY: only apply_en is high.

The next state is always the requested operation, so any state can move to any other. The move into APPLY from any other state is the one that resets the observation cell.

Top module: `pulse_scan_stage`

## Requirements
- R1: While rst_n is low, all chain cells, holding registers and the observation cell are 0, so logic_out, scan_data_out and scan_ctrl_out are all 0.
- R2: When shift_en is high, both chains advance one cell per clock. Cell 0 loads the serial input, and cell i loads cell i-1. scan_ctrl_out is control cell WIDTH-1.
- R3: While shifting, logic_out keeps the values it had before the shift began.
- R4: When update_en is high and shift_en is low, both holding registers load their chain contents in the same clock edge.
- R5: In apply mode (apply_en high, shift_en and update_en low), logic_out[i] equals pulse_strobe when control hold bit i is 1. It equals data hold bit i when that control bit is 0. Example: data hold bits 0..3 = 0,1,0,1 and control bits 0..3 = 0,0,1,0 give logic_out bits 0..3 = 0,1,strobe,1.
- R6: Outside apply mode, every logic_out bit whose control hold bit is 1 is 0, whatever the strobe does.
- R7: When all control hold bits are 0, pulse_strobe has no effect: logic_out equals the data hold register.
- R8: The requests have a fixed priority: shift over update over apply. A lower request that arrives together with a higher one is ignored for that cycle.
- R9: The observation cell loads obs_in on the first apply cycle after any other operation. On each later consecutive apply cycle it becomes its own value OR obs_in. Update and idle cycles leave it unchanged.
- R10: The observation cell is the last stage of the data chain. During a shift it loads data cell WIDTH-1, and scan_data_out always shows it. A bit therefore leaves the data output WIDTH+1 shifts after it enters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | Shift request for both chains |
| update_en | input | 1 | Copy both chains into the holding registers |
| apply_en | input | 1 | Apply mode: route the strobe and record the observed node |
| scan_data_in | input | 1 | Serial input of the data chain |
| scan_ctrl_in | input | 1 | Serial input of the control chain |
| pulse_strobe | input | 1 | Test pulse shared by all inputs of the stage |
| obs_in | input | 1 | Monitored node of the preceding stage logic |
| scan_data_out | output | 1 | Observation cell, the last stage of the data chain |
| scan_ctrl_out | output | 1 | Last cell of the control chain |
| logic_out | output | WIDTH | Logic inputs driven into the stage |

## Verification
Two groups of functions can fall in the same cycle. The first is the three requests raised together: shift with update, update with apply, or all three. These cases are produced on purpose, and each is judged by showing that only the operation with the highest priority changed chain, hold or observation state. The second is the strobe toggling during a shift or an update while control bits are set. This is judged by checking that logic_out stays frozen, with the controlled bits held at 0. A reference model is stepped on every clock and compared against the serial outputs and logic_out. Where a combinational result matters, the comparison is repeated just after the inputs change.

// File: rtl/pss_pkg.sv
package pss_pkg;
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_SHIFT  = 2'd1,
        OP_UPDATE = 2'd2,
        OP_APPLY  = 2'd3
    } op_t;
endpackage

// File: rtl/pss_ctrl.sv
module pss_ctrl
    import pss_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shift_req,
    input  logic update_req,
    input  logic apply_req,
    output logic do_shift,
    output logic do_load,
    output logic do_apply,
    output logic apply_first
);
    op_t state_q;
    op_t state_d;

    // Next state is the requested operation, taken in priority order.
    always_comb begin
        unique casez ({shift_req, update_req, apply_req})
            3'b1??:  state_d = OP_SHIFT;
            3'b01?:  state_d = OP_UPDATE;
            3'b001:  state_d = OP_APPLY;
            default: state_d = OP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        do_shift    = 1'b0;
        do_load     = 1'b0;
        do_apply    = 1'b0;
        apply_first = 1'b0;
        unique case (state_d)
            OP_SHIFT:  do_shift = 1'b1;
            OP_UPDATE: do_load  = 1'b1;
            OP_APPLY: begin
                do_apply    = 1'b1;
                apply_first = (state_q != OP_APPLY);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pss_chain.sv
module pss_chain #(
    parameter int LEN = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_i,
    input  logic           load_i,
    input  logic           sin_i,
    output logic [LEN-1:0] shadow_o,
    output logic [LEN-1:0] hold_o
);
    for (genvar g = 0; g < LEN; g++) begin : g_cell
        logic feed;
        if (g == 0) begin : g_head
            assign feed = sin_i;
        end else begin : g_body
            assign feed = shadow_o[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       shadow_o[g] <= 1'b0;
            else if (shift_i) shadow_o[g] <= feed;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      hold_o[g] <= 1'b0;
            else if (load_i) hold_o[g] <= shadow_o[g];
        end
    end
endmodule

// File: rtl/pulse_scan_stage.sv
module pulse_scan_stage #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             update_en,
    input  logic             apply_en,
    input  logic             scan_data_in,
    input  logic             scan_ctrl_in,
    input  logic             pulse_strobe,
    input  logic             obs_in,
    output logic             scan_data_out,
    output logic             scan_ctrl_out,
    output logic [WIDTH-1:0] logic_out
);
    localparam int LAST = WIDTH - 1;

    logic             do_shift, do_load, do_apply, apply_first;
    logic [WIDTH-1:0] data_shadow, data_hold;
    logic [WIDTH-1:0] ctrl_shadow, ctrl_hold;
    logic             obs_q;
    logic             strobe_gated;

    pss_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_req   (shift_en),
        .update_req  (update_en),
        .apply_req   (apply_en),
        .do_shift    (do_shift),
        .do_load     (do_load),
        .do_apply    (do_apply),
        .apply_first (apply_first)
    );

    pss_chain #(.LEN(WIDTH)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_i  (do_shift),
        .load_i   (do_load),
        .sin_i    (scan_data_in),
        .shadow_o (data_shadow),
        .hold_o   (data_hold)
    );

    pss_chain #(.LEN(WIDTH)) u_ctrl_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_i  (do_shift),
        .load_i   (do_load),
        .sin_i    (scan_ctrl_in),
        .shadow_o (ctrl_shadow),
        .hold_o   (ctrl_hold)
    );

    // Observation cell: tail of the data chain, records the node in apply mode.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           obs_q <= 1'b0;
        else if (do_shift)    obs_q <= data_shadow[LAST];
        else if (apply_first) obs_q <= obs_in;
        else if (do_apply)    obs_q <= obs_q | obs_in;
    end

    assign strobe_gated = pulse_strobe & do_apply;

    for (genvar i = 0; i < WIDTH; i++) begin : g_mux
        assign logic_out[i] = ctrl_hold[i] ? strobe_gated : data_hold[i];
    end

    assign scan_data_out = obs_q;
    assign scan_ctrl_out = ctrl_shadow[LAST];
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shift_en,
    input logic             update_en,
    input logic             apply_en,
    input logic             scan_data_out,
    input logic [WIDTH-1:0] logic_out,
    input logic [WIDTH-1:0] data_shadow,
    input logic [WIDTH-1:0] ctrl_shadow,
    input logic [WIDTH-1:0] data_hold,
    input logic [WIDTH-1:0] ctrl_hold
);
    p_shift_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en ##1 shift_en) |-> $stable(logic_out));

    p_update_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (update_en && !shift_en) |=>
            (data_hold == $past(data_shadow)) && (ctrl_hold == $past(ctrl_shadow)));

    p_strobe_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(apply_en && !shift_en && !update_en) |-> ((logic_out & ctrl_hold) == '0));

    p_no_ctrl_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hold == '0) |-> (logic_out == data_hold));

    p_shift_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> ($stable(data_hold) && $stable(ctrl_hold)));

    p_obs_tail_r10: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (scan_data_out == $past(data_shadow[WIDTH-1])));
endmodule

bind pulse_scan_stage pss_checker #(.WIDTH(WIDTH)) u_pss_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .shift_en      (shift_en),
    .update_en     (update_en),
    .apply_en      (apply_en),
    .scan_data_out (scan_data_out),
    .logic_out     (logic_out),
    .data_shadow   (data_shadow),
    .ctrl_shadow   (ctrl_shadow),
    .data_hold     (data_hold),
    .ctrl_hold     (ctrl_hold)
);

// File: tb/test_pulse_scan_stage.sv
module test_pulse_scan_stage;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shift_en = 1'b0, update_en = 1'b0, apply_en = 1'b0;
    logic         sdi = 1'b0, sci = 1'b0, pulse = 1'b0, obs = 1'b0;
    logic         sdo, sco;
    logic [W-1:0] lout;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pulse_scan_stage #(.WIDTH(W)) i_pulse_scan_stage (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .update_en(update_en),
        .apply_en(apply_en), .scan_data_in(sdi), .scan_ctrl_in(sci),
        .pulse_strobe(pulse), .obs_in(obs), .scan_data_out(sdo),
        .scan_ctrl_out(sco), .logic_out(lout)
    );

    // Reference model
    bit dq[$];
    bit cq[$];
    bit dh[W];
    bit ch[W];
    bit m_obs;
    bit m_prev_apply;

    function automatic void model_reset();
        dq.delete(); cq.delete();
        for (int i = 0; i < W; i++) begin
            dq.push_back(1'b0); cq.push_back(1'b0); dh[i] = 1'b0; ch[i] = 1'b0;
        end
        m_obs = 1'b0;
        m_prev_apply = 1'b0;
    endfunction

    function automatic bit apply_now();
        return apply_en && !shift_en && !update_en;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            if (shift_en) begin
                dq.push_front(sdi);
                m_obs = dq.pop_back();
                cq.push_front(sci);
                void'(cq.pop_back());
            end else if (update_en) begin
                for (int i = 0; i < W; i++) begin dh[i] = dq[i]; ch[i] = cq[i]; end
            end else if (apply_en) begin
                if (!m_prev_apply) m_obs = obs;
                else               m_obs = m_obs | obs;
            end
            m_prev_apply = apply_now();
        end
    end

    function automatic logic [W-1:0] exp_lout();
        logic [W-1:0] v;
        for (int i = 0; i < W; i++) v[i] = ch[i] ? (pulse & apply_now()) : dh[i];
        return v;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output against the model; tag by current mode.
    task automatic compare();
        string tag;
        if (shift_en && (update_en || apply_en)) tag = "R8";
        else if (shift_en)                       tag = "R3";
        else if (apply_now())                    tag = "R5";
        else                                     tag = "R6";
        check(tag, lout, exp_lout());
        check("R2", {{(W-1){1'b0}}, sco}, {{(W-1){1'b0}}, cq[W-1]});
        check((apply_now() || m_prev_apply) ? "R9" : "R10",
              {{(W-1){1'b0}}, sdo}, {{(W-1){1'b0}}, m_obs});
    endtask

    task automatic cyc();
        @(negedge clk);
        compare();
    endtask

    task automatic settle();
        #1;
        compare();
    endtask

    task automatic idle_in();
        shift_en = 0; update_en = 0; apply_en = 0; pulse = 0; obs = 0;
    endtask

    // Shift a pattern so that bit k lands in cell k, then update.
    task automatic load_pattern(logic [W-1:0] d, logic [W-1:0] c);
        for (int k = W - 1; k >= 0; k--) begin
            shift_en = 1; sdi = d[k]; sci = c[k];
            pulse = k[0];
            cyc();
        end
        shift_en = 0; update_en = 1; pulse = 1;
        cyc();
        update_en = 0; pulse = 0;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        #35;
        // R1: reset values
        check("R1", lout, '0);
        check("R1", {{(W-1){1'b0}}, sdo}, '0);
        check("R1", {{(W-1){1'b0}}, sco}, '0);
        @(negedge clk);
        rst_n = 1;
        cyc();

        // R5: example pattern 0,1,0,1 with control 0,0,1,0 in bits 0..3
        load_pattern(8'b1010_1010, 8'b0000_0100);
        apply_en = 1;
        pulse = 1; settle();
        check("R5", lout[3:0], 4'b1110);
        pulse = 0; settle();
        check("R5", lout[3:0], 4'b1010);
        cyc();
        pulse = 1; cyc();
        apply_en = 0; pulse = 1; settle();
        check("R6", lout[3:0], 4'b1010);
        cyc();

        // R3 and R8: shifting with strobe and other requests active
        for (int k = 0; k < 2 * W + 2; k++) begin
            shift_en = 1; sdi = k[1]; sci = k[0];
            update_en = k[2]; apply_en = k[1]; pulse = ~pulse; obs = k[0];
            cyc();
            settle();
        end
        idle_in();
        // R8: update beats apply
        update_en = 1; apply_en = 1; obs = 1; pulse = 1;
        cyc();
        idle_in();
        cyc();

        // R9: first apply loads obs_in, later cycles accumulate
        apply_en = 1; obs = 0; cyc();
        check("R9", {{(W-1){1'b0}}, sdo}, '0);
        obs = 1; cyc();
        obs = 0; cyc();
        check("R9", {{(W-1){1'b0}}, sdo}, {{(W-1){1'b0}}, 1'b1});
        apply_en = 0; cyc();
        apply_en = 1; obs = 0; cyc();
        check("R9", {{(W-1){1'b0}}, sdo}, '0);
        idle_in();

        // R10: bit leaves the data output WIDTH+1 shifts after entering
        obs = 0; apply_en = 1; cyc(); idle_in();
        shift_en = 1; sdi = 1; sci = 0; cyc();
        sdi = 0;
        for (int k = 0; k < W - 1; k++) cyc();
        check("R10", {{(W-1){1'b0}}, sdo}, '0);
        cyc();
        check("R10", {{(W-1){1'b0}}, sdo}, {{(W-1){1'b0}}, 1'b1});
        shift_en = 0; cyc();

        // R7: no control bit set, strobe has no effect
        load_pattern(8'b0110_1001, 8'b0000_0000);
        apply_en = 1;
        for (int k = 0; k < 4; k++) begin
            pulse = k[0]; settle();
            check("R7", lout, 8'b0110_1001);
            cyc();
        end
        idle_in();

        // R4: both chains updated together, all bits controlled
        load_pattern(8'b1111_0000, 8'b1111_1111);
        check("R4", lout, 8'b0000_0000);
        apply_en = 1; pulse = 1; settle();
        check("R4", lout, 8'b1111_1111);
        cyc();
        idle_in();
        cyc();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule